// File: doc/BRIEF.md
# Digital AGC Gain Loop

This block sets the receive gain word from statistics of the A/D converter output. Each valid sample brings in a magnitude and a flag that marks a converter at full scale. The block collects these over fixed windows. At the end of each window it either lowers the gain, declares lock, releases lock, or holds. After reset, and whenever receive is disabled, the gain starts at its highest code. While the signal is too strong, the gain steps down. The step is large when many samples clip, medium when a few clip, and 1 dB otherwise.

Once a clean window has an average magnitude inside the programmed lock window, the block declares lock. It then freezes the gain for the rest of the packet. It records the locking average as a reference. It drops lock when a later window average moves away from that reference by more than a programmed limit, and adjustment then resumes. Each transition from unlocked to locked produces a one-cycle carrier-sense pulse, which the receive chain uses as an early sign that a signal is present.

Top module: `agc_gain_loop`

## Requirements
- R1: While `rst_n` is low, or at any clock edge where `rx_en` is low, `gain_code` becomes the maximum code (127 for the default 7-bit gain), `agc_locked` and `cs_pulse` become 0, and any partly collected window is discarded.
- R2: Statistics are gathered over windows of WIN_LEN (default 16) samples that have `smp_valid` high. A decision is made only at the clock edge that takes the last sample of a window. Cycles with `smp_valid` low leave every output and the window contents unchanged.
- R3: At a window end, while unlocked, the gain is lowered if any sample saturated or if the window average is above `cfg_win_hi`. The step is 8 dB when the saturated count exceeds 50% of the window (9 to 16 of 16). It is 4 dB when the count exceeds 12% (2 to 8 of 16). It is 1 dB otherwise (0 or 1 of 16).
- R4: `gain_code` is in 1 dB units and saturates at 0; a step larger than the current code gives 0.
- R5: The window average is floor(sum of magnitudes / WIN_LEN). At a window end, while unlocked, a window with no saturated sample and an average in [`cfg_win_lo`, `cfg_win_hi`] (both bounds inclusive) sets `agc_locked`. That average is stored as the reference, and the gain is unchanged.
- R6: While locked, `gain_code` does not change, whatever the magnitude or saturation inputs.
- R7: At a window end, while locked, lock is dropped if |average − reference| > `cfg_unlock_delta`; a distance equal to the limit keeps lock. The gain is unchanged at that edge.
- R8: `cs_pulse` is high for exactly the one cycle after the edge at which `agc_locked` rises, and is low at all other times.
- R9: At a window end, while unlocked, a window with no saturated sample and an average below `cfg_win_lo` leaves the gain and the lock flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive enable; low restarts the loop |
| smp_valid | input | 1 | Sample strobe |
| smp_mag | input | MAG_W (8) | Sample magnitude |
| smp_sat | input | 1 | Sample hit converter full scale |
| cfg_win_lo | input | MAG_W (8) | Lower lock-window bound, inclusive |
| cfg_win_hi | input | MAG_W (8) | Upper lock-window bound, inclusive |
| cfg_unlock_delta | input | MAG_W (8) | Allowed drift from the locking average |
| gain_code | output | GAIN_W (7) | Gain word, 1 dB per code |
| agc_locked | output | 1 | Lock flag |
| cs_pulse | output | 1 | One-cycle carrier-sense pulse on lock |

## Verification
The bench builds the block with its default parameters: 16-sample windows, a 7-bit gain and 8-bit magnitudes. With these values every step-size boundary (1/2 and 8/9 saturated samples) is a single window away. Walking the gain from 127 down to the floor at 0 takes only sixteen fully saturated windows. A two-value alternating pattern exposes the floor rounding of the average at the lower lock bound. The inclusive upper bound and the equal-to-limit unlock case are reached with small magnitudes.

// File: rtl/agc_pkg.sv
package agc_pkg;

  typedef enum logic [1:0] {
    AGC_HOLD  = 2'd0,
    AGC_STEP  = 2'd1,
    AGC_LOCK  = 2'd2,
    AGC_UNLK  = 2'd3
  } agc_dec_e;

  // Step in dB chosen from the saturated-sample count of one window.
  function automatic int unsigned agc_step_db(
    input int unsigned sat_cnt,
    input int unsigned win_len,
    input int unsigned hi_pct,
    input int unsigned mid_pct,
    input int unsigned step_big,
    input int unsigned step_mid,
    input int unsigned step_small
  );
    if (sat_cnt * 100 > hi_pct * win_len)       return step_big;
    else if (sat_cnt * 100 > mid_pct * win_len) return step_mid;
    else                                         return step_small;
  endfunction

  // Gain minus step, floored at zero.
  function automatic int unsigned agc_sub_floor(
    input int unsigned gain,
    input int unsigned step
  );
    return (gain > step) ? gain - step : 0;
  endfunction

  // Absolute distance between two averages.
  function automatic int unsigned agc_dist(
    input int unsigned a,
    input int unsigned b
  );
    return (a > b) ? a - b : b - a;
  endfunction

endpackage

// File: rtl/agc_win_stats.sv
module agc_win_stats #(
  parameter int WIN_LEN = 16,
  parameter int MAG_W   = 8,
  localparam int CNT_W  = $clog2(WIN_LEN),
  localparam int SUM_W  = MAG_W + CNT_W,
  localparam int SATC_W = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              smp_valid,
  input  logic [MAG_W-1:0]  smp_mag,
  input  logic              smp_sat,
  output logic              win_done,
  output logic [MAG_W-1:0]  win_avg,
  output logic [SATC_W-1:0] win_sat_cnt
);

  logic [CNT_W-1:0]  cnt_q;
  logic [SUM_W-1:0]  sum_q, sum_nx;
  logic [SATC_W-1:0] satc_q, satc_nx;
  logic              last_smp;

  always_comb begin
    sum_nx      = sum_q + SUM_W'(smp_mag);
    satc_nx     = satc_q + SATC_W'(smp_sat);
    last_smp    = (cnt_q == CNT_W'(WIN_LEN - 1));
    win_done    = smp_valid && last_smp;
    win_avg     = sum_nx[SUM_W-1:CNT_W];
    win_sat_cnt = satc_nx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q  <= '0;
      sum_q  <= '0;
      satc_q <= '0;
    end else if (smp_valid) begin
      if (last_smp) begin
        cnt_q  <= '0;
        sum_q  <= '0;
        satc_q <= '0;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
        sum_q  <= sum_nx;
        satc_q <= satc_nx;
      end
    end
  end

endmodule

// File: rtl/agc_step_sel.sv
module agc_step_sel
  import agc_pkg::*;
#(
  parameter int WIN_LEN    = 16,
  parameter int GAIN_W     = 7,
  parameter int HI_PCT     = 50,
  parameter int MID_PCT    = 12,
  parameter int STEP_BIG   = 8,
  parameter int STEP_MID   = 4,
  parameter int STEP_SMALL = 1,
  localparam int SATC_W    = $clog2(WIN_LEN) + 1
) (
  input  logic [SATC_W-1:0] sat_cnt,
  output logic [GAIN_W-1:0] step_db
);

  always_comb begin
    step_db = GAIN_W'(agc_step_db(32'(sat_cnt), WIN_LEN, HI_PCT, MID_PCT,
                                  STEP_BIG, STEP_MID, STEP_SMALL));
  end

endmodule

// File: rtl/agc_ctrl.sv
module agc_ctrl
  import agc_pkg::*;
#(
  parameter int GAIN_W  = 7,
  parameter int MAG_W   = 8,
  parameter int SATC_W  = 5,
  localparam int GAIN_MAX = (1 << GAIN_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              win_done,
  input  logic [MAG_W-1:0]  win_avg,
  input  logic [SATC_W-1:0] win_sat_cnt,
  input  logic [GAIN_W-1:0] step_db,
  input  logic [MAG_W-1:0]  cfg_win_lo,
  input  logic [MAG_W-1:0]  cfg_win_hi,
  input  logic [MAG_W-1:0]  cfg_unlock_delta,
  output logic [GAIN_W-1:0] gain_code,
  output logic              agc_locked,
  output logic              cs_pulse,
  output agc_dec_e          dec
);

  logic [GAIN_W-1:0] gain_q;
  logic [MAG_W-1:0]  ref_q;
  logic              lock_q;
  logic              cs_q;
  logic              in_win;
  logic              clean;

  always_comb begin
    clean  = (win_sat_cnt == '0);
    in_win = (win_avg >= cfg_win_lo) && (win_avg <= cfg_win_hi);
    dec    = AGC_HOLD;
    if (win_done) begin
      if (lock_q) begin
        if (agc_dist(32'(win_avg), 32'(ref_q)) > 32'(cfg_unlock_delta))
          dec = AGC_UNLK;
      end else if (clean && in_win) begin
        dec = AGC_LOCK;
      end else if (!clean || (win_avg > cfg_win_hi)) begin
        dec = AGC_STEP;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !rx_en) begin
      gain_q <= GAIN_W'(GAIN_MAX);
      lock_q <= 1'b0;
      cs_q   <= 1'b0;
      ref_q  <= '0;
    end else begin
      cs_q <= (dec == AGC_LOCK);
      case (dec)
        AGC_STEP: gain_q <= GAIN_W'(agc_sub_floor(32'(gain_q), 32'(step_db)));
        AGC_LOCK: begin
          lock_q <= 1'b1;
          ref_q  <= win_avg;
        end
        AGC_UNLK: lock_q <= 1'b0;
        default:  ;
      endcase
    end
  end

  assign gain_code  = gain_q;
  assign agc_locked = lock_q;
  assign cs_pulse   = cs_q;

endmodule

// File: rtl/agc_gain_loop.sv
module agc_gain_loop
  import agc_pkg::*;
#(
  parameter int WIN_LEN    = 16,
  parameter int MAG_W      = 8,
  parameter int GAIN_W     = 7,
  parameter int HI_PCT     = 50,
  parameter int MID_PCT    = 12,
  parameter int STEP_BIG   = 8,
  parameter int STEP_MID   = 4,
  parameter int STEP_SMALL = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              smp_valid,
  input  logic [MAG_W-1:0]  smp_mag,
  input  logic              smp_sat,
  input  logic [MAG_W-1:0]  cfg_win_lo,
  input  logic [MAG_W-1:0]  cfg_win_hi,
  input  logic [MAG_W-1:0]  cfg_unlock_delta,
  output logic [GAIN_W-1:0] gain_code,
  output logic              agc_locked,
  output logic              cs_pulse
);

  localparam int SATC_W = $clog2(WIN_LEN) + 1;

  logic              win_done;
  logic [MAG_W-1:0]  win_avg;
  logic [SATC_W-1:0] win_sat_cnt;
  logic [GAIN_W-1:0] step_db;
  agc_dec_e          dec;

  // Named events for the checker.
  logic step_evt, lock_evt, unlock_evt;
  assign step_evt   = (dec == AGC_STEP);
  assign lock_evt   = (dec == AGC_LOCK);
  assign unlock_evt = (dec == AGC_UNLK);

  agc_win_stats #(.WIN_LEN(WIN_LEN), .MAG_W(MAG_W)) stats_i (
    .clk(clk), .rst_n(rst_n), .clr(!rx_en),
    .smp_valid(smp_valid), .smp_mag(smp_mag), .smp_sat(smp_sat),
    .win_done(win_done), .win_avg(win_avg), .win_sat_cnt(win_sat_cnt)
  );

  agc_step_sel #(
    .WIN_LEN(WIN_LEN), .GAIN_W(GAIN_W), .HI_PCT(HI_PCT), .MID_PCT(MID_PCT),
    .STEP_BIG(STEP_BIG), .STEP_MID(STEP_MID), .STEP_SMALL(STEP_SMALL)
  ) step_i (
    .sat_cnt(win_sat_cnt), .step_db(step_db)
  );

  agc_ctrl #(.GAIN_W(GAIN_W), .MAG_W(MAG_W), .SATC_W(SATC_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en),
    .win_done(win_done), .win_avg(win_avg), .win_sat_cnt(win_sat_cnt),
    .step_db(step_db), .cfg_win_lo(cfg_win_lo), .cfg_win_hi(cfg_win_hi),
    .cfg_unlock_delta(cfg_unlock_delta),
    .gain_code(gain_code), .agc_locked(agc_locked), .cs_pulse(cs_pulse),
    .dec(dec)
  );

endmodule

// File: rtl/agc_gain_loop_chk.sv
module agc_gain_loop_chk #(
  parameter int GAIN_W   = 7,
  parameter int STEP_BIG = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              win_done,
  input logic              lock_evt,
  input logic [GAIN_W-1:0] gain_code,
  input logic              agc_locked,
  input logic              cs_pulse
);

  localparam int GAIN_MAX = (1 << GAIN_W) - 1;

  p_idle_max_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (gain_code == GAIN_W'(GAIN_MAX)) && !agc_locked && !cs_pulse);

  p_only_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rx_en) |-> (gain_code <= $past(gain_code)));

  p_step_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rx_en) && (gain_code < $past(gain_code))) |->
      (32'($past(gain_code)) - 32'(gain_code) <= STEP_BIG));

  p_lock_at_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(agc_locked) |-> $past(win_done));

  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (agc_locked && rx_en) |=> (gain_code == $past(gain_code)));

  p_unlock_keeps_gain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(agc_locked) && $past(rx_en)) |-> $stable(gain_code));

  p_cs_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(agc_locked) |-> cs_pulse);

  p_cs_only_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_pulse |-> (agc_locked && !$past(agc_locked) && $past(lock_evt)));

endmodule

bind agc_gain_loop agc_gain_loop_chk #(.GAIN_W(GAIN_W), .STEP_BIG(STEP_BIG)) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .win_done(win_done),
  .lock_evt(lock_evt), .gain_code(gain_code), .agc_locked(agc_locked),
  .cs_pulse(cs_pulse)
);

// File: tb/agc_gain_loop_tb_top.sv
module agc_gain_loop_tb_top;

  typedef struct packed {
    logic [7:0] mag_a;
    logic [7:0] mag_b;
    logic [4:0] satn;
    logic [6:0] exp_gain;
    logic       exp_lock;
    logic       exp_cs;
  } vec_t;

  localparam int NVEC = 13;
  // Lock window [64,96], drift limit 16; windows applied in order from reset.
  localparam vec_t VECS [NVEC] = '{
    '{8'd200, 8'd200, 5'd16, 7'd119, 1'b0, 1'b0},  // R3 16 sat -> 8 dB
    '{8'd200, 8'd200, 5'd9,  7'd111, 1'b0, 1'b0},  // R3 9 sat -> 8 dB
    '{8'd200, 8'd200, 5'd8,  7'd107, 1'b0, 1'b0},  // R3 8 sat -> 4 dB
    '{8'd150, 8'd150, 5'd2,  7'd103, 1'b0, 1'b0},  // R3 2 sat -> 4 dB
    '{8'd150, 8'd150, 5'd1,  7'd102, 1'b0, 1'b0},  // R3 1 sat -> 1 dB
    '{8'd150, 8'd150, 5'd0,  7'd101, 1'b0, 1'b0},  // R3 above window
    '{8'd40,  8'd40,  5'd0,  7'd101, 1'b0, 1'b0},  // R9 below window
    '{8'd63,  8'd64,  5'd0,  7'd101, 1'b0, 1'b0},  // R5 floor avg 63
    '{8'd64,  8'd65,  5'd0,  7'd101, 1'b1, 1'b1},  // R5 lock at 64
    '{8'd70,  8'd70,  5'd16, 7'd101, 1'b1, 1'b0},  // R6 frozen under sat
    '{8'd80,  8'd80,  5'd0,  7'd101, 1'b1, 1'b0},  // R7 distance == limit
    '{8'd81,  8'd81,  5'd0,  7'd101, 1'b0, 1'b0},  // R7 distance 17 unlock
    '{8'd96,  8'd96,  5'd0,  7'd101, 1'b1, 1'b1}   // R5 upper bound inclusive
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0;
  logic       smp_valid = 1'b0;
  logic [7:0] smp_mag = '0;
  logic       smp_sat = 1'b0;
  logic [7:0] cfg_win_lo = 8'd64;
  logic [7:0] cfg_win_hi = 8'd96;
  logic [7:0] cfg_unlock_delta = 8'd16;
  logic [6:0] gain_code;
  logic       agc_locked;
  logic       cs_pulse;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  agc_gain_loop dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .smp_valid(smp_valid),
    .smp_mag(smp_mag), .smp_sat(smp_sat), .cfg_win_lo(cfg_win_lo),
    .cfg_win_hi(cfg_win_hi), .cfg_unlock_delta(cfg_unlock_delta),
    .gain_code(gain_code), .agc_locked(agc_locked), .cs_pulse(cs_pulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] mag, input logic sat, input logic vld);
    @(negedge clk);
    smp_mag = mag; smp_sat = sat; smp_valid = vld;
  endtask

  task automatic idle();
    @(negedge clk);
    smp_valid = 1'b0; smp_sat = 1'b0;
  endtask

  task automatic send_win(input logic [7:0] a, input logic [7:0] b, input int satn);
    for (int k = 0; k < 16; k++)
      put((k % 2 == 0) ? a : b, (k < satn), 1'b1);
    idle();
  endtask

  task automatic rx_off();
    @(negedge clk);
    smp_valid = 1'b0; rx_en = 1'b0;
    @(negedge clk);
    rx_en = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset gain", gain_code, 127);
    chk("R1 reset lock", agc_locked, 0);
    chk("R1 reset cs", cs_pulse, 0);
    rst_n = 1'b1;
    rx_en = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      send_win(VECS[i].mag_a, VECS[i].mag_b, int'(VECS[i].satn));
      chk($sformatf("vec %0d gain R3/R5/R6/R7/R9", i), gain_code, VECS[i].exp_gain);
      chk($sformatf("vec %0d lock R5/R7", i), agc_locked, VECS[i].exp_lock);
      chk($sformatf("vec %0d cs R8", i), cs_pulse, VECS[i].exp_cs);
    end

    // R8 pulse lasts one cycle
    @(negedge clk);
    chk("R8 cs drops", cs_pulse, 0);
    chk("R8 lock held", agc_locked, 1);

    // R1 rx_en low while locked
    rx_off();
    chk("R1 rx off gain", gain_code, 127);
    chk("R1 rx off lock", agc_locked, 0);

    // R2 invalid cycles ignored mid-window
    for (int k = 0; k < 15; k++) put(8'd150, 1'b0, 1'b1);
    for (int k = 0; k < 6; k++) put(8'd255, 1'b1, 1'b0);
    @(negedge clk);
    chk("R2 no decision on invalid", gain_code, 127);
    put(8'd150, 1'b0, 1'b1);
    idle();
    chk("R2 decision on 16th valid", gain_code, 126);

    // R1 partial window discarded by rx_en low
    rx_off();
    for (int k = 0; k < 10; k++) put(8'd200, 1'b1, 1'b1);
    rx_off();
    for (int k = 0; k < 6; k++) put(8'd150, 1'b0, 1'b1);
    idle();
    chk("R1 window restarted", gain_code, 127);
    for (int k = 0; k < 10; k++) put(8'd150, 1'b0, 1'b1);
    idle();
    chk("R1 restarted window decides", gain_code, 126);

    // R4 clamp at zero
    rx_off();
    for (int w = 0; w < 15; w++) send_win(8'd255, 8'd255, 16);
    chk("R4 before floor", gain_code, 7);
    send_win(8'd255, 8'd255, 16);
    chk("R4 clamp to 0", gain_code, 0);
    send_win(8'd255, 8'd255, 16);
    chk("R4 stays 0", gain_code, 0);
    chk("R4 unlocked", agc_locked, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule